// File: doc/BRIEF.md
# Slow-Clock Rising-Edge Strobe Generator

This block lets a fast clock domain react once to every rising edge of a much slower, unrelated clock without that slow clock ever reaching a logic or data input. Inside the slow domain, a toggle flop advances on each rising edge. A follower flop copies the toggle on each falling edge. The XOR of the two is an ordinary data signal shaped like the slow clock itself.

That replica crosses into the fast domain through a chain of synchronizing flops. One more flop holds the previous synchronized value. The strobe is high when the synchronized replica is 1 and the previous value is 0.

The result is a strobe exactly one fast cycle wide for each slow rising edge. A typical use is one memory write request per incoming word, for example video arriving near 27 MHz and consumed by logic near 200 MHz. Each domain has its own active-low reset.

Top module: `slow_edge_strobe`

## Requirements
- R1: While `rst_fast_n` is low, `strobe` is 0. It is also 0 on the first fast cycle after `rst_fast_n` rises.
- R2: Over any run, the number of strobes equals the number of slow rising edges, provided each slow phase lasts at least two fast periods.
- R3: `strobe` is never high on two consecutive fast cycles.
- R4: With the default two synchronizer stages, `strobe` is high in the interval after the second or third fast rising edge that follows a slow rising edge.
- R5: Slow falling edges never produce a strobe.
- R6: While `rst_slow_n` is low, the replica stays 0 and no strobe is issued, even if `clk_slow` keeps toggling.
- R7: After `rst_slow_n` is released, the toggle starts from a known 0, and the next slow rising edge gives a strobe.
- R8: After a fast-domain reset between runs, the strobe count again matches the slow rising edges.
- R9: Just before every slow rising edge out of reset, the replica is 0. Each high or low run of the synchronized replica lasts at least `MIN_PHASE` fast cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock whose rising edges are reported |
| rst_slow_n | input | 1 | Active-low asynchronous reset of the slow-domain flops |
| clk_fast | input | 1 | Fast clock that samples the replica |
| rst_fast_n | input | 1 | Active-low asynchronous reset of the fast-domain flops |
| strobe | output | 1 | One-fast-cycle pulse per slow rising edge |

## Verification
The bench drives several slow/fast ratios that are not integers. These include a phase barely over two fast periods, each with a random start offset. It checks the strobe count, strobe width and latency for each ratio.

A design that fired on both edges of the replica would double the count. An edge detector that leaves out the inverter would hold `strobe` high for the whole phase. An extra or missing synchronizer stage would shift the latency out of the two-to-three-edge window.

Directed cases cover three more faults. With the slow reset held, a toggle that escapes reset would yield strobes. If the fast domain is released while the replica is already high, a detector that is not cleared would pulse on the first cycle. After a fast reset between runs, a count that drifts shows that state was lost.

// File: rtl/slow_edge_strobe.sv
module slow_edge_strobe #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 2
) (
  input  logic clk_slow,
  input  logic rst_slow_n,
  input  logic clk_fast,
  input  logic rst_fast_n,
  output logic strobe
);
  localparam int RUN_W = $clog2(MIN_PHASE + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PHASE);

  if (SYNC_STAGES < 2) begin : g_bad_stages
    $error("SYNC_STAGES must be at least 2");
  end
  if (MIN_PHASE < 2) begin : g_bad_phase
    $error("MIN_PHASE must be at least 2");
  end

  logic tog_q, follow_q, replica;

  always_ff @(posedge clk_slow or negedge rst_slow_n)
    if (!rst_slow_n) tog_q <= 1'b0;
    else             tog_q <= ~tog_q;

  always_ff @(negedge clk_slow or negedge rst_slow_n)
    if (!rst_slow_n) follow_q <= 1'b0;
    else             follow_q <= tog_q;

  assign replica = tog_q ^ follow_q;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, level;

  always_ff @(posedge clk_fast or negedge rst_fast_n)
    if (!rst_fast_n) sync_q <= '0;
    else             sync_q <= {sync_q[SYNC_STAGES-2:0], replica};

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_fast or negedge rst_fast_n)
    if (!rst_fast_n) prev_q <= 1'b0;
    else             prev_q <= level;

  assign strobe = level & ~prev_q;

  // R9
  replica_low_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !replica);

  // R3
  one_cycle_chk: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    strobe |=> !strobe);

  // R4
  level_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    strobe |=> level);

  // R1
  always_comb begin
    reset_quiet_chk: assert (rst_fast_n || !strobe);
  end

  logic [RUN_W-1:0] run_q;
  logic armed_q;

  always_ff @(posedge clk_fast or negedge rst_fast_n)
    if (!rst_fast_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else if (level != prev_q) begin
      run_q   <= RUN_W'(1);
      armed_q <= 1'b1;
    end else if (run_q < RUN_MAX) begin
      run_q   <= run_q + RUN_W'(1);
    end

  // R9
  phase_width_chk: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    (armed_q && level != prev_q) |-> run_q >= RUN_MAX);
endmodule

// File: tb/slow_edge_strobe_tb.sv
`timescale 1ps/1ps
module slow_edge_strobe_tb;
  logic clk_slow = 1'b0, rst_slow_n = 1'b0;
  logic clk_fast = 1'b0, rst_fast_n = 1'b0;
  logic strobe;

  int tests = 0, fails = 0;
  int fedge = 0, rise_at = -100;
  int pulses = 0, bad_lat = 0, dbl = 0;
  bit mon_en = 1'b0, last_s = 1'b0, done = 1'b0;

  slow_edge_strobe u_dut (
    .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
    .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
    .strobe(strobe)
  );

  always #10000 clk_fast = ~clk_fast;

  always @(posedge clk_fast) fedge++;
  always @(posedge clk_slow) rise_at = fedge;

  always @(negedge clk_fast) begin
    if (mon_en && strobe) begin
      pulses++;
      if (fedge - rise_at < 2 || fedge - rise_at > 3) bad_lat++;
      if (last_s) dbl++;
    end
    last_s = strobe;
  end

  // half period in ps (even), rising edges per run
  localparam int NVEC = 5;
  localparam int VEC [NVEC][2] = '{
    '{74074, 60}, '{55556, 80}, '{40002, 100}, '{123456, 40}, '{97530, 50}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_slow(input int half, input int n);
    int off = 2 * int'($urandom % 10000) + 1;
    #(off);
    repeat (n) begin
      clk_slow = 1'b1; #(half);
      clk_slow = 1'b0; #(half);
    end
    repeat (5) @(negedge clk_fast);
  endtask

  task automatic clear_mon();
    pulses = 0; bad_lat = 0; dbl = 0; rise_at = -100;
  endtask

  initial begin
    #(150_000_000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R6: slow reset held while slow clock toggles
    rst_fast_n = 1'b1;
    repeat (3) @(negedge clk_fast);
    clear_mon(); mon_en = 1'b1;
    run_slow(74074, 10);
    mon_en = 1'b0;
    check(pulses == 0, "R6 no strobe in slow reset", pulses, 0);

    // R1: fast reset quiet, first cycle after release quiet, even with replica high
    rst_fast_n = 1'b0;
    @(negedge clk_fast);
    rst_slow_n = 1'b1;
    @(negedge clk_fast);
    clk_slow = 1'b1;
    repeat (2) @(negedge clk_fast);
    check(strobe == 1'b0, "R1 strobe low in fast reset", strobe, 0);
    rst_fast_n = 1'b1;
    @(negedge clk_fast);
    check(strobe == 1'b0, "R1 strobe low first cycle after reset", strobe, 0);
    @(negedge clk_fast);
    check(strobe == 1'b1, "R7 strobe after first rise out of reset", strobe, 1);
    @(negedge clk_fast);
    check(strobe == 1'b0, "R3 strobe one cycle wide", strobe, 0);
    #(40002);
    clk_slow = 1'b0;
    repeat (6) @(negedge clk_fast);

    // R2 R3 R4 R5: table walk
    for (int v = 0; v < NVEC; v++) begin
      clear_mon(); mon_en = 1'b1;
      run_slow(VEC[v][0], VEC[v][1]);
      mon_en = 1'b0;
      check(pulses == VEC[v][1], "R2 one strobe per rise", pulses, VEC[v][1]);
      check(bad_lat == 0, "R4/R5 latency 2..3 fast edges", bad_lat, 0);
      check(dbl == 0, "R3 no back-to-back strobe", dbl, 0);
    end

    // R8: fast reset between runs, then count again
    rst_fast_n = 1'b0;
    repeat (3) @(negedge clk_fast);
    check(strobe == 1'b0, "R8 strobe low in mid-test reset", strobe, 0);
    rst_fast_n = 1'b1;
    @(negedge clk_fast);
    clear_mon(); mon_en = 1'b1;
    run_slow(66666, 70);
    mon_en = 1'b0;
    check(pulses == 70, "R8 count after fast reset", pulses, 70);
    check(bad_lat == 0 && dbl == 0, "R8 strobe timing after fast reset", bad_lat + dbl, 0);

    // R7: slow reset pulse, then strobes resume
    rst_slow_n = 1'b0;
    repeat (2) @(negedge clk_fast);
    rst_slow_n = 1'b1;
    clear_mon(); mon_en = 1'b1;
    run_slow(81818, 25);
    mon_en = 1'b0;
    check(pulses == 25, "R7 strobes resume after slow reset", pulses, 25);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule